// File: doc/BRIEF.md
# Three-Wire Serial Byte EEPROM Slave

This block is a synthesizable model of a byte-wide serial EEPROM that a host reaches over three wires: a select line, a serial clock and a serial data input, with one serial data output coming back. The array holds either 128 or 256 bytes, set by the address width parameter. All serial inputs are brought into the system clock domain through two-flop synchronisers. Serial bits are then taken on rising serial clock edges while select is high.

Each command begins with a 1 start bit, followed by a two-bit opcode and an address field. Reads return data at once. Programming commands are collected in full and acted on when select drops. They then hold the block busy for a fixed number of system clock cycles, and the host sees this as a low level on the data output. Programming is refused until an enable command has been received.

Top module: `mw_eeprom`

## Requirements
- R1: After reset every byte reads 0xFF, writes are disabled and the data output is 0 while select is low.
- R2: While idle, 0 bits on the data input are skipped; the first 1 sampled with select high is the start bit.
- R3: Opcode 10 (read) followed by the address field drives a 0 on the data output after the last address bit, then the 8 stored bits MSB first, one per following serial clock rising edge.
- R4: Opcode 01 (write) followed by the address field and 8 data bits (MSB first) stores the byte at that address when select falls.
- R5: Opcode 11 (erase) followed by the address field sets the addressed byte to 0xFF when select falls; other bytes keep their values.
- R6: Opcode 00 whose field starts with 01, then don't-care bits to fill the field, then 8 data bits, writes that byte to every address.
- R7: Opcode 00 whose field starts with 10 sets every byte to 0xFF.
- R8: Opcode 00 whose field starts with 11 enables programming and 00 disables it; a write, erase, fill or clear received while disabled changes no byte and starts no busy period.
- R9: An accepted programming command makes the block busy for WCYC system clock cycles after select falls. With select high the data output is 0 while busy and 1 when ready, and a command sent while busy is ignored.
- R10: The address field is ADDR_W bits for 128 bytes and, for 256 bytes, one leading dummy bit plus 8 address bits; the fill and clear sub-opcode takes the first two bits of that field.
- R11: A command cut short by select falling before all of its bits arrived has no effect and starts no busy period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sclk_i | input | 1 | Serial clock, bits taken on its rising edge |
| sdi_i | input | 1 | Serial data into the block |
| sdo_o | output | 1 | Serial data out: read data, or ready/busy status |

## Verification
The assertions assume that every serial input level lasts well beyond the three-cycle synchroniser and edge-detect delay, and that select stays low for more than one system clock once it drops. They also assume that no programming command can finish while the block is still busy. The stimulus meets these assumptions because it holds every serial clock phase and every select transition for six system clocks. The busy period in the bench is also far longer than any command frame, so a command sent during it always starts and ends while the block is busy.

// File: rtl/mw_pkg.sv
// Shared encodings for the serial EEPROM slave.
// Assumes: opcode and sub-opcode values are fixed by the serial command grammar.
package mw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } mw_state_t;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] SUB_DIS   = 2'b00;
    localparam logic [1:0] SUB_FILL  = 2'b01;
    localparam logic [1:0] SUB_CLR   = 2'b10;
    localparam logic [1:0] SUB_EN    = 2'b11;
endpackage

// File: rtl/mw_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes: each bit is independent; inputs change slowly compared with clk.
module mw_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: move the bundle one stage further into the clk domain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= (s == 0) ? d_i : chain[(s == 0) ? 0 : s - 1];
            end
        end
    endgenerate

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/mw_cmd.sv
// Serial command decoder: finds the start bit, gathers opcode, address
// field and data, streams read data and issues an execute strobe when
// select falls after a complete programming or control command.
// Assumes: inputs are already synchronised; rdata_i follows addr_o.
module mw_cmd
    import mw_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              sk_i,
    input  logic              di_i,
    input  logic              busy_i,
    input  logic [7:0]        rdata_i,
    output logic              go_o,
    output logic [1:0]        op_o,
    output logic [1:0]        sub_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [7:0]        data_o,
    output logic              rd_mode_o,
    output logic              rd_bit_o
);
    localparam int DUMMY = (ADDR_W > 7) ? 1 : 0;
    localparam int FLD_W = ADDR_W + DUMMY;
    localparam int HDR_W = 2 + FLD_W;
    localparam int CNT_W = $clog2(HDR_W + 8);

    mw_state_t        state;
    logic [HDR_W-1:0] hdr;
    logic [HDR_W-1:0] hdr_nxt;
    logic [7:0]       dat;
    logic [CNT_W-1:0] cnt;
    logic             sk_q, cs_q;
    logic             sk_rise, cs_fall;
    logic [1:0]       nxt_op, nxt_sub;
    logic [2:0]       ridx;

    // Purpose: remember last levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk_i;
            cs_q <= cs_i;
        end
    end

    // Purpose: edge strobes and the header as it would look after this bit.
    always_comb begin
        sk_rise = sk_i & ~sk_q;
        cs_fall = cs_q & ~cs_i;
        hdr_nxt = {hdr[HDR_W-2:0], di_i};
        nxt_op  = hdr_nxt[HDR_W-1:HDR_W-2];
        nxt_sub = hdr_nxt[HDR_W-3:HDR_W-4];
        ridx    = 3'(3'd7 - cnt[2:0]);
    end

    // Purpose: command state machine, shifting and execute strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            hdr      <= '0;
            dat      <= '0;
            cnt      <= '0;
            go_o     <= 1'b0;
            rd_bit_o <= 1'b0;
        end else begin
            go_o <= 1'b0;
            if (!cs_i) begin
                go_o     <= cs_fall && (state == ST_DONE) && (op_o != OPC_READ);
                state    <= ST_IDLE;
                cnt      <= '0;
                rd_bit_o <= 1'b0;
            end else if (sk_rise) begin
                case (state)
                    ST_IDLE: begin
                        if (di_i && !busy_i) begin
                            state <= ST_HDR;
                            cnt   <= '0;
                        end
                    end
                    ST_HDR: begin
                        hdr <= hdr_nxt;
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(HDR_W - 1)) begin
                            cnt <= '0;
                            if (nxt_op == OPC_READ) begin
                                state    <= ST_READ;
                                rd_bit_o <= 1'b0;
                            end else if (nxt_op == OPC_WRITE ||
                                         (nxt_op == OPC_EXT && nxt_sub == SUB_FILL)) begin
                                state <= ST_DATA;
                            end else begin
                                state <= ST_DONE;
                            end
                        end
                    end
                    ST_DATA: begin
                        dat <= {dat[6:0], di_i};
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(7)) state <= ST_DONE;
                    end
                    ST_READ: begin
                        rd_bit_o <= rdata_i[ridx];
                        cnt      <= cnt + 1'b1;
                        if (cnt == CNT_W'(7)) state <= ST_DONE;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign op_o      = hdr[HDR_W-1:HDR_W-2];
    assign sub_o     = hdr[HDR_W-3:HDR_W-4];
    assign addr_o    = hdr[ADDR_W-1:0];
    assign data_o    = dat;
    assign rd_mode_o = (state == ST_READ) || (state == ST_DONE && op_o == OPC_READ);

    // R9
    idle_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && busy_i) |=> (state == ST_IDLE));

    // R11
    exec_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> !cs_i);
endmodule

// File: rtl/mw_array.sv
// Byte array with enable latch and timed programming cycle.
// Assumes: go_i is a one-cycle strobe carrying a complete command.
module mw_array
    import mw_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int WCYC   = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [1:0]        op_i,
    input  logic [1:0]        sub_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic              busy_o,
    output logic [7:0]        rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int TMR_W = $clog2(WCYC + 1);

    logic [7:0]       mem [DEPTH];
    logic             wen_q;
    logic [TMR_W-1:0] tmr;
    logic             is_prog, prog;

    // Purpose: decide whether this strobe starts a programming cycle.
    always_comb begin
        is_prog = (op_i == OPC_WRITE) || (op_i == OPC_ERASE) ||
                  (op_i == OPC_EXT && (sub_i == SUB_FILL || sub_i == SUB_CLR));
        prog    = go_i && !busy_o && wen_q && is_prog;
    end

    // Purpose: enable latch and busy timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q  <= 1'b0;
            busy_o <= 1'b0;
            tmr    <= '0;
        end else begin
            if (go_i && !busy_o && op_i == OPC_EXT) begin
                if (sub_i == SUB_EN)       wen_q <= 1'b1;
                else if (sub_i == SUB_DIS) wen_q <= 1'b0;
            end
            if (prog) begin
                busy_o <= 1'b1;
                tmr    <= TMR_W'(WCYC);
            end else if (busy_o) begin
                if (tmr == TMR_W'(1)) busy_o <= 1'b0;
                tmr <= tmr - 1'b1;
            end
        end
    end

    // Purpose: byte storage, single-byte and whole-array updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (prog) begin
            if (op_i == OPC_EXT) begin
                for (int i = 0; i < DEPTH; i++)
                    mem[i] <= (sub_i == SUB_FILL) ? data_i : 8'hFF;
            end else begin
                mem[addr_i] <= (op_i == OPC_WRITE) ? data_i : 8'hFF;
            end
        end
    end

    assign rdata_o = mem[addr_i];

    // R8
    locked_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !busy_o && !wen_q && is_prog) |=> !busy_o);

    // R8
    latch_only_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(go_i) |-> $stable(wen_q));

    // R9
    busy_from_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(go_i));

    // R6
    fill_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !busy_o && wen_q && op_i == OPC_EXT && sub_i == SUB_FILL)
        |=> (mem[0] == $past(data_i) && mem[DEPTH-1] == $past(data_i)));
endmodule

// File: rtl/mw_eeprom.sv
// Top of the three-wire serial EEPROM slave: synchronises the serial
// pins, decodes commands and drives read data or ready/busy status.
// Assumes: serial pin levels last several clk cycles.
module mw_eeprom #(
    parameter int ADDR_W = 7,
    parameter int WCYC   = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sclk_i,
    input  logic sdi_i,
    output logic sdo_o
);
    logic              cs_s, sk_s, di_s;
    logic              go, busy, rd_mode, rd_bit;
    logic [1:0]        op, sub;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        wdata, rdata;

    mw_sync #(.W(3), .STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({cs_i, sclk_i, sdi_i}),
        .q_o  ({cs_s, sk_s, di_s})
    );

    mw_cmd #(.ADDR_W(ADDR_W)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_i     (cs_s),
        .sk_i     (sk_s),
        .di_i     (di_s),
        .busy_i   (busy),
        .rdata_i  (rdata),
        .go_o     (go),
        .op_o     (op),
        .sub_o    (sub),
        .addr_o   (addr),
        .data_o   (wdata),
        .rd_mode_o(rd_mode),
        .rd_bit_o (rd_bit)
    );

    mw_array #(.ADDR_W(ADDR_W), .WCYC(WCYC)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .go_i   (go),
        .op_i   (op),
        .sub_i  (sub),
        .addr_i (addr),
        .data_i (wdata),
        .busy_o (busy),
        .rdata_o(rdata)
    );

    // Purpose: output select between read stream and ready/busy level.
    always_comb begin
        if (!cs_s)       sdo_o = 1'b0;
        else if (rd_mode) sdo_o = rd_bit;
        else              sdo_o = ~busy;
    end
endmodule

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
    localparam int ADDR_W = 8;
    localparam int WCYC   = 600;
    localparam int HALF   = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
    logic sdo;
    int   n_tests = 0, n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    mw_eeprom #(.ADDR_W(ADDR_W), .WCYC(WCYC)) dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sclk_i(sclk), .sdi_i(sdi), .sdo_o(sdo)
    );

    // kind[17:16]: 0 write, 1 read-and-compare, 2 erase; addr[15:8]; data[7:0]
    localparam logic [17:0] VEC [10] = '{
        {2'd0, 8'h05, 8'hA5}, {2'd1, 8'h05, 8'hA5},
        {2'd0, 8'hFF, 8'h3C}, {2'd1, 8'hFF, 8'h3C},
        {2'd0, 8'h7F, 8'hC3}, {2'd1, 8'h7F, 8'hC3},
        {2'd1, 8'hFF, 8'h3C}, {2'd2, 8'h05, 8'h00},
        {2'd1, 8'h05, 8'hFF}, {2'd1, 8'h7F, 8'hC3}
    };

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(logic b);
        sdi = b; idle(HALF); sclk = 1'b1; idle(HALF); sclk = 1'b0;
    endtask

    task automatic header(logic [1:0] op, logic [8:0] fld);
        cs = 1'b1; idle(HALF);
        bit_out(1'b1); bit_out(op[1]); bit_out(op[0]);
        for (int i = 8; i >= 0; i--) bit_out(fld[i]);
    endtask

    task automatic drop_cs();
        sclk = 1'b0; sdi = 1'b0; idle(HALF); cs = 1'b0; idle(HALF);
    endtask

    task automatic wait_ready(string tag);
        int n = 0;
        cs = 1'b1; idle(HALF);
        while (n < WCYC + 50 && sdo !== 1'b1) begin idle(1); n++; end
        chk(tag, 16'(sdo), 16'h1);
        cs = 1'b0; idle(HALF);
    endtask

    task automatic send_data(logic [7:0] d);
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        header(2'b01, {1'b0, a}); send_data(d); drop_cs(); wait_ready("R4 ready");
    endtask

    task automatic er(logic [7:0] a);
        header(2'b11, {1'b0, a}); drop_cs(); wait_ready("R5 ready");
    endtask

    task automatic ext(logic [1:0] sub, logic [7:0] d);
        header(2'b00, {sub, 7'h00});
        if (sub == 2'b01) send_data(d);
        drop_cs(); wait_ready("R8 ready");
    endtask

    task automatic rd(logic [7:0] a, logic [7:0] exp, string tag);
        logic [7:0] got;
        header(2'b10, {1'b0, a});
        idle(HALF);
        chk({tag, " R3 dummy"}, 16'(sdo), 16'h0);
        for (int i = 7; i >= 0; i--) begin
            bit_out(1'b0); idle(HALF); got[i] = sdo;
        end
        chk(tag, 16'(got), 16'(exp));
        drop_cs();
    endtask

    task automatic no_busy(string tag);
        cs = 1'b1; idle(HALF); chk(tag, 16'(sdo), 16'h1); cs = 1'b0; idle(HALF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(4); rst_n = 1'b1; idle(4);
        // R1: reset state
        chk("R1 sdo low with cs low", 16'(sdo), 16'h0);
        rd(8'h10, 8'hFF, "R1 erased after reset");
        // R8: locked after reset, write ignored and no busy
        header(2'b01, 9'h010); send_data(8'h55); drop_cs();
        no_busy("R8 locked write no busy");
        rd(8'h10, 8'hFF, "R8 locked write ignored");
        ext(2'b11, 8'h00);
        // R4 R5 R10: table walk
        foreach (VEC[k]) begin
            case (VEC[k][17:16])
                2'd0: wr(VEC[k][15:8], VEC[k][7:0]);
                2'd1: rd(VEC[k][15:8], VEC[k][7:0], "R4 R5 R10 table read");
                default: er(VEC[k][15:8]);
            endcase
        end
        // R2: leading zeros before start bit
        cs = 1'b1; idle(HALF); bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
        rd(8'hFF, 8'h3C, "R2 leading zeros skipped");
        // R11: truncated write
        header(2'b01, 9'h005); bit_out(1'b0); bit_out(1'b1); drop_cs();
        no_busy("R11 truncated no busy");
        rd(8'h05, 8'hFF, "R11 truncated ignored");
        // R9: busy level and duration, command during busy ignored
        header(2'b01, 9'h020); send_data(8'h11); drop_cs();
        cs = 1'b1; idle(HALF);
        chk("R9 busy reads low", 16'(sdo), 16'h0);
        begin
            int n = 0;
            while (n < WCYC + 50 && sdo !== 1'b1) begin idle(1); n++; end
            chk("R9 busy duration", 16'(n > WCYC - 40 && n < WCYC + 10), 16'h1);
        end
        cs = 1'b0; idle(HALF);
        header(2'b01, 9'h021); send_data(8'h22); drop_cs();
        header(2'b01, 9'h022); send_data(8'h33); drop_cs();
        wait_ready("R9 ready after busy");
        rd(8'h21, 8'h22, "R9 first write stored");
        rd(8'h22, 8'hFF, "R9 write during busy ignored");
        // R6: fill all
        ext(2'b01, 8'h6B);
        rd(8'h00, 8'h6B, "R6 fill low");
        rd(8'hFF, 8'h6B, "R6 fill high");
        rd(8'h80, 8'h6B, "R6 fill mid");
        // R8: disable then programming ignored
        ext(2'b00, 8'h00);
        header(2'b01, 9'h030); send_data(8'h77); drop_cs();
        no_busy("R8 disabled no busy");
        rd(8'h30, 8'h6B, "R8 disabled write ignored");
        header(2'b00, 9'h100); drop_cs();
        rd(8'h31, 8'h6B, "R8 disabled clear ignored");
        // R7: clear all
        ext(2'b11, 8'h00);
        ext(2'b10, 8'h00);
        rd(8'h31, 8'hFF, "R7 clear all");
        rd(8'hFE, 8'hFF, "R7 clear all high");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule